// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit sits beside an instruction decoder and resolves where an operand comes from. Given the program counter of the operand field, an addressing-mode code, the index pair H:X, the stack pointer and a short embedded field from the opcode, it walks a byte-wide memory port one read per cycle. It gathers address or offset bytes that follow the opcode, forms the effective address, reads a byte or a big-endian 16-bit word there, and hands back the value together with the advanced program counter and the possibly incremented index.

A request is a one-cycle `start` pulse while the unit is idle. The unit then stays busy for as many cycles as it performs reads. It ends with a one-cycle `done` pulse that carries the result, or with a one-cycle `err` pulse if the mode cannot serve the requested width. Instruction execution and the memory array are outside the block: the memory answers `mem_rdata` in the same cycle as `mem_addr`.

Top module: `oag_unit`

## Requirements
- R1: A word access (`wide`=1) returns the byte at the effective address in bits 15:8 and the byte at effective address plus 1 in bits 7:0. The plus 1 wraps from 0xFFFF to 0x0000. A byte access returns 0x00 in bits 15:8.
- R2: Mode 0 (immediate) reads the operand at PC (and PC+1 for a word), and `pc_out` is PC+1 for a byte or PC+2 for a word.
- R3: Mode 1 (direct short) takes the byte at PC, zero-extended, as the address, with `pc_out`=PC+1. Mode 2 (direct long) takes the bytes at PC and PC+1 as a big-endian address, with `pc_out`=PC+2.
- R4: Modes 4 and 5 add a zero-extended byte offset (at PC), or a big-endian word offset (at PC, PC+1), to H:X. Modes 6 and 7 do the same with SP. All additions wrap modulo 2^16, and `pc_out` advances by the number of offset bytes.
- R5: Mode 3 addresses H:X directly and returns `pc_out` equal to PC.
- R6: Mode 8 addresses 0x0000 to 0x000F from `field[3:0]` (bit 4 ignored). Mode 9 addresses 0x0000 to 0x001F from `field[4:0]`. Neither reads PC bytes, and both return `pc_out`=PC. Both are byte-only.
- R7: Mode 10 reads the byte at H:X and returns `hx_out`=H:X+1 (wrapping) with `pc_out`=PC. It is byte-only. Every other mode returns `hx_out` equal to the H:X given.
- R8: Mode 11 (word-only) reads a direct address byte at PC and the byte at that address. It returns bits 15:8 as 0x01 or 0x00 from bit `field[2:0]` of that byte, and bits 7:0 as the byte at PC+1, with `pc_out`=PC+2.
- R9: Each memory read takes one cycle with `mem_rd` high. `done` is a one-cycle pulse in the cycle after the last read, and `result`, `pc_out` and `hx_out` are valid with it.
- R10: Codes 12 to 15, a word request in modes 8, 9 or 10, and a byte request in mode 11 raise a one-cycle `err` in the cycle after `start`. No read and no `done` follow.
- R11: After reset `busy`, `mem_rd`, `done`, `err`, `result`, `pc_out` and `hx_out` are all zero.
- R12: A `start` while `busy` is high is ignored: the running request completes unchanged and no second request is begun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| mode | input | 4 | Addressing-mode code |
| wide | input | 1 | 1 = 16-bit word access, 0 = byte |
| pc_in | input | 16 | PC of the first operand byte |
| hx_in | input | 16 | Index pair H:X |
| sp_in | input | 16 | Stack pointer |
| field | input | 5 | Opcode-embedded short address or bit number |
| mem_rd | output | 1 | Read strobe for this cycle |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, same cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Illegal mode/width pulse |
| result | output | 16 | Operand value |
| pc_out | output | 16 | Advanced program counter |
| hx_out | output | 16 | Index after optional post-increment |

## Verification
The case where two functions share a cycle is a new `start` arriving while the read sequence of an earlier request is still driving `mem_addr`. The bench raises `start` with a different mode and width in the second busy cycle of a four-read long-direct word fetch. The judgement rests on the reference model alone: `done` must still appear exactly once, one cycle after the fourth read, with the first request's result, PC and index. No stray `done` or `err` may follow.

// File: rtl/oag_pkg.sv
// Shared types for the operand address generation unit.
// Assumes byte-wide memory and 16-bit words; mode codes are fixed here.
package oag_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [3:0] {
        M_IMM     = 4'd0,
        M_DIR8    = 4'd1,
        M_DIR16   = 4'd2,
        M_IX0     = 4'd3,
        M_IX8     = 4'd4,
        M_IX16    = 4'd5,
        M_SP8     = 4'd6,
        M_SP16    = 4'd7,
        M_TINY    = 4'd8,
        M_SHORT   = 4'd9,
        M_IX0_INC = 4'd10,
        M_BITTST  = 4'd11
    } oag_mode_e;

    typedef enum logic [2:0] {
        B_ZERO, B_PC, B_HX, B_SP, B_FIELD4, B_FIELD5
    } base_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_OPND, ST_DATA, ST_BIMM
    } seq_st_e;

    typedef struct packed {
        logic       legal;
        logic [1:0] opnd_cnt;
        logic [1:0] data_cnt;
        base_e      base;
        logic       bittst;
        logic       postinc;
        logic [1:0] pc_adv;
    } plan_t;
endpackage

// File: rtl/oag_decode.sv
// Mode decoder: turns a mode code and access width into a fetch plan.
// Assumes nothing about timing; purely combinational.
module oag_decode
    import oag_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       wide,
    output plan_t      plan
);
    logic [1:0] nb;

    // Build the plan: operand byte count, base, data count and PC advance.
    always_comb begin
        nb = wide ? 2'd2 : 2'd1;
        plan          = '0;
        plan.legal    = 1'b1;
        plan.base     = B_ZERO;
        plan.data_cnt = nb;
        case (mode)
            M_IMM:     begin plan.base = B_PC; plan.pc_adv = nb; end
            M_DIR8:    begin plan.opnd_cnt = 2'd1; plan.pc_adv = 2'd1; end
            M_DIR16:   begin plan.opnd_cnt = 2'd2; plan.pc_adv = 2'd2; end
            M_IX0:     begin plan.base = B_HX; end
            M_IX8:     begin plan.base = B_HX; plan.opnd_cnt = 2'd1; plan.pc_adv = 2'd1; end
            M_IX16:    begin plan.base = B_HX; plan.opnd_cnt = 2'd2; plan.pc_adv = 2'd2; end
            M_SP8:     begin plan.base = B_SP; plan.opnd_cnt = 2'd1; plan.pc_adv = 2'd1; end
            M_SP16:    begin plan.base = B_SP; plan.opnd_cnt = 2'd2; plan.pc_adv = 2'd2; end
            M_TINY:    begin plan.base = B_FIELD4; plan.legal = !wide; end
            M_SHORT:   begin plan.base = B_FIELD5; plan.legal = !wide; end
            M_IX0_INC: begin plan.base = B_HX; plan.postinc = 1'b1; plan.legal = !wide; end
            M_BITTST:  begin
                plan.opnd_cnt = 2'd1;
                plan.data_cnt = 2'd1;
                plan.bittst   = 1'b1;
                plan.pc_adv   = 2'd2;
                plan.legal    = wide;
            end
            default:   plan.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/oag_ea.sv
// Effective-address adder: selects a base and adds the gathered offset.
// Assumes the offset is zero when the mode fetches no operand bytes.
module oag_ea
    import oag_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 5
) (
    input  base_e             base,
    input  logic [AW-1:0]     pc,
    input  logic [AW-1:0]     hx,
    input  logic [AW-1:0]     sp,
    input  logic [FW-1:0]     field,
    input  logic [WORD_W-1:0] opnd,
    output logic [AW-1:0]     ea
);
    logic [AW-1:0] base_val;

    // Pick the base register or the short field.
    always_comb begin
        case (base)
            B_PC:     base_val = pc;
            B_HX:     base_val = hx;
            B_SP:     base_val = sp;
            B_FIELD4: base_val = AW'(field[3:0]);
            B_FIELD5: base_val = AW'(field);
            default:  base_val = '0;
        endcase
    end

    // Wrapping add of base and offset.
    assign ea = base_val + AW'(opnd);
endmodule

// File: rtl/oag_seq.sv
// Read sequencer: latches a request, issues one memory read per cycle
// (operand bytes, data bytes, bit-test immediate) and posts the result.
// Assumes memory returns read data in the same cycle as the address.
module oag_seq
    import oag_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  plan_t             plan_in,
    input  logic [AW-1:0]     pc_in,
    input  logic [AW-1:0]     hx_in,
    input  logic [AW-1:0]     sp_in,
    input  logic [FW-1:0]     field_in,
    input  logic [AW-1:0]     ea,
    input  logic [BYTE_W-1:0] mem_rdata,
    output base_e             base_r,
    output logic [AW-1:0]     pc_r,
    output logic [AW-1:0]     hx_r,
    output logic [AW-1:0]     sp_r,
    output logic [FW-1:0]     field_r,
    output logic [WORD_W-1:0] opnd_r,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] result,
    output logic [AW-1:0]     pc_out,
    output logic [AW-1:0]     hx_out
);
    seq_st_e           st;
    plan_t             plan_r;
    logic              idx_r;
    logic              bit_r;
    logic [WORD_W-1:0] data_r;
    logic              opnd_last;
    logic              data_last;
    logic              fin;
    logic [WORD_W-1:0] fin_val;

    assign base_r = plan_r.base;
    assign busy   = (st != ST_IDLE);
    assign mem_rd = busy;

    // Drive the read address for the current phase.
    always_comb begin
        case (st)
            ST_OPND: mem_addr = pc_r + AW'(idx_r);
            ST_DATA: mem_addr = ea + AW'(idx_r);
            ST_BIMM: mem_addr = pc_r + AW'(1);
            default: mem_addr = '0;
        endcase
    end

    // Decide whether this read ends the request and what it yields.
    always_comb begin
        opnd_last = ({1'b0, idx_r} + 2'd1) == plan_r.opnd_cnt;
        data_last = ({1'b0, idx_r} + 2'd1) == plan_r.data_cnt;
        fin       = 1'b0;
        fin_val   = {data_r[BYTE_W-1:0], mem_rdata};
        if (st == ST_DATA && !plan_r.bittst && data_last) begin
            fin = 1'b1;
        end else if (st == ST_BIMM) begin
            fin     = 1'b1;
            fin_val = {{(BYTE_W-1){1'b0}}, bit_r, mem_rdata};
        end
    end

    // Phase sequencing, request latching and result posting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            plan_r  <= '0;
            idx_r   <= 1'b0;
            bit_r   <= 1'b0;
            data_r  <= '0;
            opnd_r  <= '0;
            pc_r    <= '0;
            hx_r    <= '0;
            sp_r    <= '0;
            field_r <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            result  <= '0;
            pc_out  <= '0;
            hx_out  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (!plan_in.legal) begin
                            err <= 1'b1;
                        end else begin
                            plan_r  <= plan_in;
                            pc_r    <= pc_in;
                            hx_r    <= hx_in;
                            sp_r    <= sp_in;
                            field_r <= field_in;
                            opnd_r  <= '0;
                            data_r  <= '0;
                            idx_r   <= 1'b0;
                            st      <= (plan_in.opnd_cnt != 2'd0) ? ST_OPND : ST_DATA;
                        end
                    end
                end
                ST_OPND: begin
                    opnd_r <= {opnd_r[BYTE_W-1:0], mem_rdata};
                    if (opnd_last) begin
                        idx_r <= 1'b0;
                        st    <= ST_DATA;
                    end else begin
                        idx_r <= 1'b1;
                    end
                end
                ST_DATA: begin
                    if (plan_r.bittst) begin
                        bit_r <= mem_rdata[field_r[2:0]];
                        st    <= ST_BIMM;
                    end else if (!data_last) begin
                        data_r <= {data_r[BYTE_W-1:0], mem_rdata};
                        idx_r  <= 1'b1;
                    end
                end
                default: ;
            endcase
            if (fin) begin
                done   <= 1'b1;
                result <= fin_val;
                pc_out <= pc_r + AW'(plan_r.pc_adv);
                hx_out <= hx_r + AW'(plan_r.postinc);
                st     <= ST_IDLE;
            end
        end
    end

    // R9: done lasts a single cycle.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: done only follows a cycle that performed a read.
    assert_done_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_rd));
    // R10: an error pulse comes with no read and no done.
    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !done));
    // R6: short-field modes stay inside their small windows.
    assert_field_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && (plan_r.base == B_FIELD4 || plan_r.base == B_FIELD5)) |->
        (mem_addr < ((plan_r.base == B_FIELD4) ? AW'(16) : AW'(32))));
    // R7: the index moves by at most one step.
    assert_hx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hx_out == hx_r || hx_out == hx_r + AW'(1)));
endmodule

// File: rtl/oag_unit.sv
// Operand address generation unit top: decoder, sequencer and EA adder.
// Assumes a same-cycle byte-wide read port and one request at a time.
module oag_unit
    import oag_pkg::*;
#(
    parameter int AW = 16,
    parameter int FW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic              wide,
    input  logic [AW-1:0]     pc_in,
    input  logic [AW-1:0]     hx_in,
    input  logic [AW-1:0]     sp_in,
    input  logic [FW-1:0]     field,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] result,
    output logic [AW-1:0]     pc_out,
    output logic [AW-1:0]     hx_out
);
    plan_t             plan;
    base_e             base_r;
    logic [AW-1:0]     pc_r;
    logic [AW-1:0]     hx_r;
    logic [AW-1:0]     sp_r;
    logic [FW-1:0]     field_r;
    logic [WORD_W-1:0] opnd_r;
    logic [AW-1:0]     ea;

    oag_decode u_dec (
        .mode (mode),
        .wide (wide),
        .plan (plan)
    );

    oag_seq #(.AW(AW), .FW(FW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .plan_in   (plan),
        .pc_in     (pc_in),
        .hx_in     (hx_in),
        .sp_in     (sp_in),
        .field_in  (field),
        .ea        (ea),
        .mem_rdata (mem_rdata),
        .base_r    (base_r),
        .pc_r      (pc_r),
        .hx_r      (hx_r),
        .sp_r      (sp_r),
        .field_r   (field_r),
        .opnd_r    (opnd_r),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .result    (result),
        .pc_out    (pc_out),
        .hx_out    (hx_out)
    );

    oag_ea #(.AW(AW), .FW(FW)) u_ea (
        .base  (base_r),
        .pc    (pc_r),
        .hx    (hx_r),
        .sp    (sp_r),
        .field (field_r),
        .opnd  (opnd_r),
        .ea    (ea)
    );
endmodule

// File: tb/oag_unit_bench.sv
// Bench for oag_unit: behavioural reference model, per-cycle comparison.
module oag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic        wide = 1'b0;
    logic [15:0] pc_in = '0, hx_in = '0, sp_in = '0;
    logic [4:0]  field = '0;
    logic        mem_rd, busy, done, err;
    logic [15:0] mem_addr, result, pc_out, hx_out;
    logic [7:0]  mem_rdata;
    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    // Synthetic memory: every byte is a function of its address.
    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] v;
        v = (a[7:0] * 8'd29) + (a[15:8] * 8'd11) + 8'h47;
        return v;
    endfunction

    assign mem_rdata = memf(mem_addr);

    oag_unit u_oag_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wide(wide),
        .pc_in(pc_in), .hx_in(hx_in), .sp_in(sp_in), .field(field),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .err(err), .result(result),
        .pc_out(pc_out), .hx_out(hx_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and compare every cycle against the model.
    task automatic run_op(input logic [3:0] m, input logic w, input logic [15:0] pc,
                          input logic [15:0] hx, input logic [15:0] sp,
                          input logic [4:0] fld, input bit inject, input string tag);
        logic [15:0] ea, a, res, pcn, hxn;
        int nb, reads;
        bit legal;
        logic [7:0] b;
        nb = w ? 2 : 1;
        legal = 1; hxn = hx; pcn = pc; ea = '0; reads = 0; res = '0;
        case (m)
            4'd0: begin ea = pc; reads = nb; pcn = pc + 16'(nb); end
            4'd1: begin ea = {8'h00, memf(pc)}; reads = 1 + nb; pcn = pc + 16'd1; end
            4'd2: begin ea = {memf(pc), memf(pc + 16'd1)}; reads = 2 + nb; pcn = pc + 16'd2; end
            4'd3: begin ea = hx; reads = nb; end
            4'd4: begin ea = hx + {8'h00, memf(pc)}; reads = 1 + nb; pcn = pc + 16'd1; end
            4'd5: begin ea = hx + {memf(pc), memf(pc + 16'd1)}; reads = 2 + nb; pcn = pc + 16'd2; end
            4'd6: begin ea = sp + {8'h00, memf(pc)}; reads = 1 + nb; pcn = pc + 16'd1; end
            4'd7: begin ea = sp + {memf(pc), memf(pc + 16'd1)}; reads = 2 + nb; pcn = pc + 16'd2; end
            4'd8: begin legal = !w; ea = {12'h000, fld[3:0]}; reads = 1; end
            4'd9: begin legal = !w; ea = {11'h000, fld}; reads = 1; end
            4'd10: begin legal = !w; ea = hx; reads = 1; hxn = hx + 16'd1; end
            4'd11: begin legal = w; reads = 3; pcn = pc + 16'd2; end
            default: legal = 0;
        endcase
        if (m == 4'd11) begin
            a = {8'h00, memf(pc)};
            b = memf(a);
            res = {7'b0, b[fld[2:0]], memf(pc + 16'd1)};
        end else if (nb == 2) begin
            res = {memf(ea), memf(ea + 16'd1)};
        end else begin
            res = {8'h00, memf(ea)};
        end
        if (!legal) reads = 0;

        @(negedge clk);
        mode = m; wide = w; pc_in = pc; hx_in = hx; sp_in = sp; field = fld; start = 1'b1;
        for (int k = 1; k <= reads + 1; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (inject && k == 2) begin
                start = 1'b1; mode = 4'd3; wide = 1'b0; hx_in = 16'h0040;
            end
            if (inject && k == 3) start = 1'b0;
            if (legal) begin
                chk({tag, " R9 done timing"}, {31'b0, done}, {31'b0, (k == reads + 1)});
                chk({tag, " R9 busy"}, {31'b0, busy}, {31'b0, (k <= reads)});
                if (k == reads + 1) begin
                    chk({tag, " result"}, {16'h0, result}, {16'h0, res});
                    chk({tag, " pc_out"}, {16'h0, pc_out}, {16'h0, pcn});
                    chk({tag, " R7 hx_out"}, {16'h0, hx_out}, {16'h0, hxn});
                end
            end else begin
                chk({tag, " R10 err"}, {31'b0, err}, 32'd1);
                chk({tag, " R10 no done"}, {31'b0, done}, 32'd0);
            end
        end
        @(negedge clk);
        chk({tag, " quiet after"}, {30'b0, done, err}, 32'd0);
        chk({tag, " R12 idle after"}, {31'b0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset flags", {28'b0, busy, mem_rd, done, err}, 32'd0);
        chk("R11 reset result", {16'h0, result}, 32'd0);
        chk("R11 reset pc/hx", {pc_out, hx_out}, 32'd0);

        run_op(4'd0, 1'b0, 16'h1234, 16'h0, 16'h0, 5'd0, 0, "R2 imm byte");
        run_op(4'd0, 1'b1, 16'hFFFF, 16'h0, 16'h0, 5'd0, 0, "R2 R1 imm word wrap");
        run_op(4'd1, 1'b0, 16'h2200, 16'h0, 16'h0, 5'd0, 0, "R3 dir8 byte");
        run_op(4'd1, 1'b1, 16'h2301, 16'h0, 16'h0, 5'd0, 0, "R3 R1 dir8 word");
        run_op(4'd2, 1'b1, 16'h4410, 16'h0, 16'h0, 5'd0, 1, "R3 R12 dir16 word busy start");
        run_op(4'd2, 1'b0, 16'h0005, 16'h0, 16'h0, 5'd0, 0, "R3 dir16 byte");
        run_op(4'd3, 1'b0, 16'h7777, 16'h8123, 16'h0, 5'd0, 0, "R5 ix0 byte");
        run_op(4'd3, 1'b1, 16'h7777, 16'hFFFF, 16'h0, 5'd0, 0, "R5 R1 ix0 word wrap");
        run_op(4'd4, 1'b1, 16'h0310, 16'hFFF0, 16'h0, 5'd0, 0, "R4 ix8 word wrap");
        run_op(4'd5, 1'b0, 16'h0520, 16'h9000, 16'h0, 5'd0, 0, "R4 ix16 byte");
        run_op(4'd6, 1'b0, 16'h0630, 16'h0, 16'h01F0, 5'd0, 0, "R4 sp8 byte");
        run_op(4'd7, 1'b1, 16'h0740, 16'h0, 16'hC000, 5'd0, 0, "R4 sp16 word");
        run_op(4'd8, 1'b0, 16'h0850, 16'h0, 16'h0, 5'h1B, 0, "R6 tiny");
        run_op(4'd9, 1'b0, 16'h0960, 16'h0, 16'h0, 5'h1B, 0, "R6 short");
        run_op(4'd10, 1'b0, 16'h0A70, 16'hFFFF, 16'h0, 5'd0, 0, "R7 postinc wrap");
        run_op(4'd10, 1'b0, 16'h0A70, 16'h1234, 16'h0, 5'd0, 0, "R7 postinc");
        for (int bn = 0; bn < 8; bn++) begin
            run_op(4'd11, 1'b1, 16'h0B00 + 16'(bn * 3), 16'h0, 16'h0, 5'(bn), 0, "R8 bit test");
        end
        run_op(4'd12, 1'b0, 16'h0100, 16'h0, 16'h0, 5'd0, 0, "R10 code 12");
        run_op(4'd15, 1'b1, 16'h0100, 16'h0, 16'h0, 5'd0, 0, "R10 code 15");
        run_op(4'd8, 1'b1, 16'h0100, 16'h0, 16'h0, 5'd3, 0, "R10 tiny word");
        run_op(4'd10, 1'b1, 16'h0100, 16'h10, 16'h0, 5'd0, 0, "R10 postinc word");
        run_op(4'd11, 1'b0, 16'h0100, 16'h0, 16'h0, 5'd1, 0, "R10 bit test byte");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule